// File: doc/BRIEF.md
# System Management Mode Entry Sequencer

This block decides when a processor core enters system management mode and then steps through entry and exit. A request comes either from an asynchronous active-low interrupt pin or from a one-cycle pulse issued by a software trigger instruction. Two configuration bits decide which of the two sources is honoured. No request is honoured while the configured region size is zero.

On entry the block saves a small header through a memory write port. The header holds the captured trap address, the trap data, and a flag word marking I/O versus memory access and video-window origin. The block then asserts real mode and redirects instruction fetch to the region base. A resume pulse reads the header back through the same port, presents the restored fields, and returns to normal execution.

Nested entry is allowed only when a dedicated enable bit is set. In that case a depth counter keeps the mode active until the outermost resume.

Top module: `smm_entry_seq`

## Requirements
- R1: The pin request is recognised only when `cfg_use_pin`=1, `cfg_sw_sel`=0 and `cfg_region_size`!=0. Otherwise a qualified pin assertion starts no header traffic.
- R2: The instruction pulse `smi_insn` is recognised only when `cfg_use_pin`=1, `cfg_sw_sel`=1 and `cfg_region_size`!=0.
- R3: `smi_n` passes a two-flop synchroniser. It counts as a request only after being seen low for two consecutive synchronised cycles, so a single-cycle low is ignored. One request is raised per assertion.
- R4: On entry, three words are written in order with `hdr_write`=1:
  - trap address at `cfg_hdr_addr`+0;
  - trap data at +4;
  - flags at +8, with bit0 = I/O access and bit1 = video-window origin.
  
  Each word, with its address, is held until `hdr_ready` is seen high.
- R5: In the cycle after the last write is accepted, `fetch_redirect` is high for exactly one cycle with `fetch_addr` = `cfg_region_base`. `real_mode` is high from that cycle on.
- R6: `in_smm` is high from the redirect cycle until the outermost restore completes, and low outside that span.
- R7: When `rsm_insn` arrives in SMM, the three header words are read (`hdr_write`=0) from the same addresses, and then `restore_valid` is high for one cycle carrying the restored fields. When no nesting level remains, `in_smm` and `real_mode` are low in that cycle.
- R8: An `rsm_insn` pulse while `in_smm` is low causes no header traffic. It raises `illegal_rsm` for exactly the following cycle.
- R9: With `cfg_nest_en`=0, a request recognised in SMM stays pending. No header traffic starts until the resume completes, and then a new entry follows.
- R10: With `cfg_nest_en`=1, a request in SMM starts a nested entry. After the inner resume `in_smm` stays high, and only the outer resume clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| smi_n | input | 1 | Asynchronous active-low interrupt pin |
| smi_insn | input | 1 | One-cycle software trigger pulse |
| rsm_insn | input | 1 | One-cycle resume pulse |
| cfg_use_pin | input | 1 | Master enable for recognition |
| cfg_sw_sel | input | 1 | 1 selects the instruction source, 0 selects the pin |
| cfg_nest_en | input | 1 | Allows nested entry |
| cfg_region_size | input | 4 | Region size; zero blocks recognition |
| cfg_region_base | input | 32 | Handler region base address |
| cfg_hdr_addr | input | 32 | Header location |
| trap_addr | input | 32 | Trapped access address |
| trap_data | input | 32 | Trapped access data |
| trap_is_io | input | 1 | Trapped access was I/O |
| trap_vga | input | 1 | Trapped access hit the video window |
| hdr_valid | output | 1 | Header port request |
| hdr_write | output | 1 | 1 write, 0 read |
| hdr_addr_o | output | 32 | Header word address |
| hdr_wdata | output | 32 | Header write data |
| hdr_ready | input | 1 | Header port accepts the request |
| hdr_rdata | input | 32 | Header read data, valid with ready |
| real_mode | output | 1 | Core forced to real mode |
| fetch_redirect | output | 1 | One-cycle fetch redirect |
| fetch_addr | output | 32 | Redirect target |
| in_smm | output | 1 | Management mode active |
| restore_valid | output | 1 | Restored fields valid |
| restore_addr | output | 32 | Restored trap address |
| restore_data | output | 32 | Restored trap data |
| restore_is_io | output | 1 | Restored I/O flag |
| restore_vga | output | 1 | Restored video flag |
| illegal_rsm | output | 1 | Resume seen outside SMM |

## Verification
The bench builds the block with `QUAL_CYC`=2 and `NEST_W`=2. This keeps the glitch-rejection window at its specified length while leaving room for one nested level plus margin. With a two-cycle window, both a single-cycle glitch and a minimal two-cycle assertion can be driven and told apart at the ports. The small depth counter brings nested entry and unwinding into reach within a few hundred cycles. A stalling header port, driven by a toggling ready, exercises the hold rule on every word.

// File: rtl/smm_seq_pkg.sv
package smm_seq_pkg;
  localparam int SMM_AW    = 32;
  localparam int SMM_DW    = 32;
  localparam int HDR_WORDS = 3;
  localparam int IDX_W     = $clog2(HDR_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_ENTER, ST_IN_SMM, ST_RESTORE, ST_EXIT
  } smm_state_e;

  // byte address of header word idx
  function automatic logic [SMM_AW-1:0] hdr_word_addr(
    input logic [SMM_AW-1:0] base, input logic [IDX_W-1:0] idx);
    return base + (SMM_AW'(idx) << 2);
  endfunction

  // content of header word idx
  function automatic logic [SMM_DW-1:0] hdr_word_data(
    input logic [IDX_W-1:0] idx, input logic [SMM_AW-1:0] a,
    input logic [SMM_DW-1:0] d, input logic io, input logic vga);
    logic [SMM_DW-1:0] w;
    case (idx)
      IDX_W'(0): w = SMM_DW'(a);
      IDX_W'(1): w = d;
      default:   w = {{(SMM_DW-2){1'b0}}, vga, io};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/smm_pin_qual.sv
module smm_pin_qual #(
  parameter int QUAL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_low,
  output logic qual_pulse
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
    end
  end

  assign sync_low = ~s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!sync_low)              cnt <= '0;
    else if (cnt != CW'(QUAL_CYC))   cnt <= cnt + 1'b1;
  end

  assign qual_pulse = sync_low && (cnt == CW'(QUAL_CYC - 1));
endmodule

// File: rtl/smm_req_gate.sv
module smm_req_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_qual,
  input  logic       sw_pulse,
  input  logic       use_pin,
  input  logic       sw_sel,
  input  logic [3:0] region_size,
  input  logic       take,
  output logic       req_set,
  output logic       pending
);
  logic size_ok, pin_ok, sw_ok;

  assign size_ok = (region_size != 4'd0);
  assign pin_ok  = use_pin & ~sw_sel & size_ok;
  assign sw_ok   = use_pin &  sw_sel & size_ok;
  assign req_set = (pin_qual & pin_ok) | (sw_pulse & sw_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (req_set) pending <= 1'b1;
    else if (take)    pending <= 1'b0;
  end
endmodule

// File: rtl/smm_nest_ctr.sv
module smm_nest_ctr #(
  parameter int NEST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [NEST_W-1:0] depth,
  output logic              full,
  output logic              nonzero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      depth <= '0;
    else if (inc && !dec && !full)   depth <= depth + 1'b1;
    else if (dec && !inc && nonzero) depth <= depth - 1'b1;
  end

  assign full    = (depth == {NEST_W{1'b1}});
  assign nonzero = (depth != '0);
endmodule

// File: rtl/smm_entry_seq.sv
module smm_entry_seq
  import smm_seq_pkg::*;
#(
  parameter int QUAL_CYC = 2,
  parameter int NEST_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_n,
  input  logic              smi_insn,
  input  logic              rsm_insn,
  input  logic              cfg_use_pin,
  input  logic              cfg_sw_sel,
  input  logic              cfg_nest_en,
  input  logic [3:0]        cfg_region_size,
  input  logic [SMM_AW-1:0] cfg_region_base,
  input  logic [SMM_AW-1:0] cfg_hdr_addr,
  input  logic [SMM_AW-1:0] trap_addr,
  input  logic [SMM_DW-1:0] trap_data,
  input  logic              trap_is_io,
  input  logic              trap_vga,
  output logic              hdr_valid,
  output logic              hdr_write,
  output logic [SMM_AW-1:0] hdr_addr_o,
  output logic [SMM_DW-1:0] hdr_wdata,
  input  logic              hdr_ready,
  input  logic [SMM_DW-1:0] hdr_rdata,
  output logic              real_mode,
  output logic              fetch_redirect,
  output logic [SMM_AW-1:0] fetch_addr,
  output logic              in_smm,
  output logic              restore_valid,
  output logic [SMM_AW-1:0] restore_addr,
  output logic [SMM_DW-1:0] restore_data,
  output logic              restore_is_io,
  output logic              restore_vga,
  output logic              illegal_rsm
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);

  smm_state_e state;
  logic [IDX_W-1:0] widx;

  // named internal events
  logic sync_low, pin_qual, req_set, pending, take;
  logic save_acc, save_done, rstr_acc, rstr_done, rsm_go;
  logic nest_full, nest_nz, can_take;
  logic [NEST_W-1:0] depth;

  logic [SMM_AW-1:0] cap_addr;
  logic [SMM_DW-1:0] cap_data;
  logic cap_io, cap_vga, real_q, illegal_q;

  smm_pin_qual #(.QUAL_CYC(QUAL_CYC)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(smi_n),
    .sync_low(sync_low), .qual_pulse(pin_qual)
  );

  smm_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pin_qual(pin_qual), .sw_pulse(smi_insn),
    .use_pin(cfg_use_pin), .sw_sel(cfg_sw_sel), .region_size(cfg_region_size),
    .take(take), .req_set(req_set), .pending(pending)
  );

  smm_nest_ctr #(.NEST_W(NEST_W)) u_nest (
    .clk(clk), .rst_n(rst_n), .inc(save_done), .dec(rstr_done),
    .depth(depth), .full(nest_full), .nonzero(nest_nz)
  );

  assign rsm_go    = (state == ST_IN_SMM) && rsm_insn;
  assign can_take  = (state == ST_IDLE) ||
                     ((state == ST_IN_SMM) && cfg_nest_en && !nest_full && !rsm_insn);
  assign take      = pending && can_take;
  assign save_acc  = (state == ST_SAVE) && hdr_ready;
  assign save_done = save_acc && (widx == LAST_IDX);
  assign rstr_acc  = (state == ST_RESTORE) && hdr_ready;
  assign rstr_done = rstr_acc && (widx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      widx  <= '0;
    end else begin
      case (state)
        ST_IDLE:    if (take) begin state <= ST_SAVE; widx <= '0; end
        ST_SAVE:    if (save_acc) begin
                      if (save_done) state <= ST_ENTER;
                      else           widx  <= widx + 1'b1;
                    end
        ST_ENTER:   state <= ST_IN_SMM;
        ST_IN_SMM:  if (rsm_go) begin state <= ST_RESTORE; widx <= '0; end
                    else if (take) begin state <= ST_SAVE; widx <= '0; end
        ST_RESTORE: if (rstr_acc) begin
                      if (rstr_done) state <= ST_EXIT;
                      else           widx  <= widx + 1'b1;
                    end
        ST_EXIT:    state <= nest_nz ? ST_IN_SMM : ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // trap context is captured when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0; cap_data <= '0; cap_io <= 1'b0; cap_vga <= 1'b0;
    end else if (take) begin
      cap_addr <= trap_addr; cap_data <= trap_data;
      cap_io   <= trap_is_io; cap_vga <= trap_vga;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restore_addr <= '0; restore_data <= '0;
      restore_is_io <= 1'b0; restore_vga <= 1'b0;
    end else if (rstr_acc) begin
      case (widx)
        IDX_W'(0): restore_addr <= SMM_AW'(hdr_rdata);
        IDX_W'(1): restore_data <= hdr_rdata;
        default: begin
          restore_is_io <= hdr_rdata[0];
          restore_vga   <= hdr_rdata[1];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      real_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (save_done)                           real_q <= 1'b1;
      else if ((state == ST_EXIT) && !nest_nz) real_q <= 1'b0;
      illegal_q <= rsm_insn && !in_smm;
    end
  end

  assign in_smm         = nest_nz;
  assign real_mode      = real_q && nest_nz;
  assign illegal_rsm    = illegal_q;
  assign hdr_valid      = (state == ST_SAVE) || (state == ST_RESTORE);
  assign hdr_write      = (state == ST_SAVE);
  assign hdr_addr_o     = hdr_valid ? hdr_word_addr(cfg_hdr_addr, widx) : '0;
  assign hdr_wdata      = hdr_write ? hdr_word_data(widx, cap_addr, cap_data, cap_io, cap_vga) : '0;
  assign fetch_redirect = (state == ST_ENTER);
  assign fetch_addr     = cfg_region_base;
  assign restore_valid  = (state == ST_EXIT);
endmodule

// File: rtl/smm_entry_seq_chk.sv
module smm_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        hdr_write,
  input logic        hdr_ready,
  input logic [31:0] hdr_addr_o,
  input logic        fetch_redirect,
  input logic        real_mode,
  input logic        in_smm,
  input logic        illegal_rsm,
  input logic        restore_valid,
  input logic        pin_qual,
  input logic        sync_low
);
  AST_PIN_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pin_qual |-> $past(sync_low)); // R3
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_addr_o) && $stable(hdr_write))); // R4
  AST_REDIRECT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |=> !fetch_redirect); // R5
  AST_REDIRECT_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |-> (real_mode && in_smm)); // R6
  AST_RESTORE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> $past(hdr_valid && !hdr_write && hdr_ready)); // R7
  AST_ILLEGAL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rsm |-> !$past(in_smm)); // R8
endmodule

bind smm_entry_seq smm_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_write(hdr_write),
  .hdr_ready(hdr_ready), .hdr_addr_o(hdr_addr_o), .fetch_redirect(fetch_redirect),
  .real_mode(real_mode), .in_smm(in_smm), .illegal_rsm(illegal_rsm),
  .restore_valid(restore_valid), .pin_qual(pin_qual), .sync_low(sync_low)
);

// File: tb/smm_entry_seq_tb_top.sv
module smm_entry_seq_tb_top;
  localparam logic [31:0] HDR_BASE = 32'h0003_FF00;
  localparam logic [31:0] RGN_BASE = 32'h0003_0000;
  // vector: {use_pin, sw_sel, size[3:0], trig(1=insn), expect}
  localparam logic [7:0] VEC [8] = '{
    {1'b1, 1'b0, 4'd5, 1'b0, 1'b1}, {1'b1, 1'b1, 4'd5, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd5, 1'b0, 1'b0}, {1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'd3, 1'b1, 1'b1}, {1'b1, 1'b0, 4'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd3, 1'b1, 1'b0}, {1'b1, 1'b1, 4'd0, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic smi_n = 1'b1, smi_insn = 1'b0, rsm_insn = 1'b0;
  logic cfg_use_pin = 1'b0, cfg_sw_sel = 1'b0, cfg_nest_en = 1'b0;
  logic [3:0] cfg_region_size = 4'd0;
  logic [31:0] trap_addr = '0, trap_data = '0;
  logic trap_is_io = 1'b0, trap_vga = 1'b0;
  logic hdr_valid, hdr_write, hdr_ready, real_mode, fetch_redirect, in_smm;
  logic restore_valid, restore_is_io, restore_vga, illegal_rsm;
  logic [31:0] hdr_addr_o, hdr_wdata, hdr_rdata, fetch_addr, restore_addr, restore_data;
  logic rdy_all = 1'b1, tick = 1'b0;
  logic [31:0] bmem [0:7];
  logic [31:0] wlog [0:7];
  int wr_cnt = 0, rd_cnt = 0, errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  smm_entry_seq #(.QUAL_CYC(2), .NEST_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .smi_n(smi_n), .smi_insn(smi_insn), .rsm_insn(rsm_insn),
    .cfg_use_pin(cfg_use_pin), .cfg_sw_sel(cfg_sw_sel), .cfg_nest_en(cfg_nest_en),
    .cfg_region_size(cfg_region_size), .cfg_region_base(RGN_BASE), .cfg_hdr_addr(HDR_BASE),
    .trap_addr(trap_addr), .trap_data(trap_data), .trap_is_io(trap_is_io), .trap_vga(trap_vga),
    .hdr_valid(hdr_valid), .hdr_write(hdr_write), .hdr_addr_o(hdr_addr_o), .hdr_wdata(hdr_wdata),
    .hdr_ready(hdr_ready), .hdr_rdata(hdr_rdata), .real_mode(real_mode),
    .fetch_redirect(fetch_redirect), .fetch_addr(fetch_addr), .in_smm(in_smm),
    .restore_valid(restore_valid), .restore_addr(restore_addr), .restore_data(restore_data),
    .restore_is_io(restore_is_io), .restore_vga(restore_vga), .illegal_rsm(illegal_rsm)
  );

  assign hdr_ready = rdy_all | tick;
  assign hdr_rdata = bmem[hdr_addr_o[4:2]];

  always @(posedge clk) begin
    tick <= ~tick;
    cyc  <= cyc + 1;
    if (hdr_valid && hdr_ready) begin
      if (hdr_write) begin
        bmem[hdr_addr_o[4:2]] <= hdr_wdata;
        wlog[wr_cnt[2:0]]     <= hdr_addr_o;
        wr_cnt <= wr_cnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) if (cyc == 100000) begin
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog: run hung, actual=%0d expected<100000 cycles", cyc);
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // which: 0 hdr_valid, 1 fetch_redirect, 2 restore_valid
  task automatic wait_sig(input int which, input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if ((which == 0 && hdr_valid) || (which == 1 && fetch_redirect) ||
          (which == 2 && restore_valid)) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic pulse_insn();
    @(negedge clk) smi_insn = 1'b1;
    @(negedge clk) smi_insn = 1'b0;
  endtask

  task automatic pulse_rsm();
    @(negedge clk) rsm_insn = 1'b1;
    @(negedge clk) rsm_insn = 1'b0;
  endtask

  task automatic pin_low(input int n);
    @(negedge clk) smi_n = 1'b0;
    repeat (n) @(negedge clk);
    smi_n = 1'b1;
  endtask

  task automatic leave_smm();
    bit s;
    wait_sig(1, 30, s);
    pulse_rsm();
    wait_sig(2, 30, s);
    @(negedge clk);
  endtask

  initial begin
    bit s;
    repeat (3) @(negedge clk);
    // reset state
    check(!hdr_valid && !in_smm && !real_mode && !illegal_rsm && !fetch_redirect,
          "R6 reset", {hdr_valid, in_smm, real_mode, illegal_rsm}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // recognition table (R1 pin, R2 instruction)
    foreach (VEC[k]) begin
      cfg_use_pin = VEC[k][7]; cfg_sw_sel = VEC[k][6]; cfg_region_size = VEC[k][5:2];
      if (VEC[k][1]) pulse_insn(); else pin_low(3);
      wait_sig(0, 15, s);
      check(s == VEC[k][0], VEC[k][1] ? "R2 recognition" : "R1 recognition",
            32'(s), 32'(VEC[k][0]));
      if (s) leave_smm();
      repeat (3) @(negedge clk);
    end

    // R3: single-cycle glitch ignored, two-cycle low accepted
    cfg_use_pin = 1'b1; cfg_sw_sel = 1'b0; cfg_region_size = 4'd2;
    pin_low(1);
    wait_sig(0, 12, s);
    check(!s, "R3 glitch", 32'(s), 32'h0);
    pin_low(2);
    wait_sig(0, 12, s);
    check(s, "R3 two-cycle", 32'(s), 32'h1);
    if (s) leave_smm();

    // R4/R5: header content and redirect, with stalling port
    cfg_sw_sel = 1'b1; rdy_all = 1'b0;
    trap_addr = 32'hDEAD_1234; trap_data = 32'h0BAD_F00D; trap_is_io = 1'b1; trap_vga = 1'b1;
    wr_cnt = 0;
    pulse_insn();
    wait_sig(1, 40, s);
    check(s && fetch_addr == RGN_BASE, "R5 redirect", fetch_addr, RGN_BASE);
    check(real_mode && in_smm, "R5 real_mode R6 in_smm", {real_mode, in_smm}, 32'h3);
    check(wr_cnt == 3, "R4 write count", wr_cnt, 3);
    check(bmem[0] == 32'hDEAD_1234, "R4 word0", bmem[0], 32'hDEAD_1234);
    check(bmem[1] == 32'h0BAD_F00D, "R4 word1", bmem[1], 32'h0BAD_F00D);
    check(bmem[2] == 32'h3, "R4 flags", bmem[2], 32'h3);
    check(wlog[0] == HDR_BASE && wlog[1] == HDR_BASE + 4 && wlog[2] == HDR_BASE + 8,
          "R4 addresses", wlog[2], HDR_BASE + 8);
    @(negedge clk);
    check(!fetch_redirect && in_smm, "R5 one-cycle redirect", {fetch_redirect, in_smm}, 32'h1);
    trap_addr = '0; trap_data = '0; trap_is_io = 1'b0; trap_vga = 1'b0;

    // R7: restore
    rd_cnt = 0;
    pulse_rsm();
    wait_sig(2, 40, s);
    check(s && restore_addr == 32'hDEAD_1234 && restore_data == 32'h0BAD_F00D,
          "R7 restored words", restore_data, 32'h0BAD_F00D);
    check(restore_is_io && restore_vga && rd_cnt == 3, "R7 flags and reads", rd_cnt, 3);
    check(!in_smm && !real_mode, "R7 exit", {in_smm, real_mode}, 32'h0);
    rdy_all = 1'b1;
    repeat (2) @(negedge clk);

    // R8: illegal resume
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk) rsm_insn = 1'b1;
    @(negedge clk);
    check(illegal_rsm, "R8 illegal pulse", 32'(illegal_rsm), 32'h1);
    rsm_insn = 1'b0;
    @(negedge clk);
    check(!illegal_rsm, "R8 illegal one cycle", 32'(illegal_rsm), 32'h0);
    repeat (5) @(negedge clk);
    check(wr_cnt == 0 && rd_cnt == 0 && !in_smm, "R8 no traffic", wr_cnt + rd_cnt, 0);

    // R9: no nesting, request held pending
    cfg_nest_en = 1'b0;
    pulse_insn();
    wait_sig(1, 30, s);
    pulse_insn();
    wait_sig(0, 8, s);
    check(!s && in_smm, "R9 held while in SMM", 32'(s), 32'h0);
    pulse_rsm();
    wait_sig(2, 30, s);
    wait_sig(1, 30, s);
    check(s, "R9 serviced after exit", 32'(s), 32'h1);
    leave_smm();
    check(!in_smm, "R9 final exit", 32'(in_smm), 32'h0);

    // R10: nesting
    cfg_nest_en = 1'b1;
    pulse_insn();
    wait_sig(1, 30, s);
    pulse_insn();
    wait_sig(1, 30, s);
    check(s, "R10 nested entry", 32'(s), 32'h1);
    pulse_rsm();
    wait_sig(2, 30, s);
    check(in_smm, "R10 inner exit keeps in_smm", 32'(in_smm), 32'h1);
    @(negedge clk);
    pulse_rsm();
    wait_sig(2, 30, s);
    check(s && !in_smm, "R10 outer exit", 32'(in_smm), 32'h0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule